// File: doc/BRIEF.md
# Display Memory Host Address Generator

This block turns host data accesses into addresses for a display memory laid out as 132 columns by 9 pages, each page covering eight pixel rows. A page register selects the row group and an 8-bit loadable column counter selects the column. Every accepted host read or write emits one registered memory request carrying the page, the physical column and, for writes, the data. After each request the column counter advances by one.

Once the counter moves past the last real column (131), it stops. Further accesses make no request and do not advance the count until a column-load command writes a new value. A mirror command reverses the column order, so that logical column c addresses physical column 131 − c. The last page (page 8) is a single-bit icon row, so only bit 0 of the write data is carried there. Three commands share one strobe: load page, load column and set mirror.

Top module: `dram_addr_gen`

## Requirements
- R1: After reset, cur_col is 0, cur_page is 0, mirror_on is 0 and ram_req is 0.
- R2: A page-load command (cmd_op = 0) with cmd_data from 0 to 8 sets cur_page to that value on the next cycle. A value above 8 leaves cur_page unchanged.
- R3: A column-load command (cmd_op = 1) sets cur_col to cmd_data on the next cycle, whatever its value. Loading a value below 132 releases a locked counter.
- R4: Each accepted access (acc_valid while cur_col < 132) raises cur_col by exactly one on the next cycle, unless a column load arrives in the same cycle.
- R5: While cur_col is 132 or above, an access is ignored. ram_req stays 0 on the next cycle and cur_col is not changed.
- R6: The cycle after an accepted access, ram_col equals the logical column when mirroring is off, and 131 minus it when mirroring is on. A mirror command (cmd_op = 2) sets mirror_on to cmd_data bit 0.
- R7: The cycle after an accepted access, ram_req is 1, ram_page is the page in effect, and ram_we is 1 for a write (acc_write = 1) and 0 for a read.
- R8: On page 8, ram_wdata carries only bit 0 of acc_wdata and its upper bits are 0. On pages 0 to 7, all bits pass unchanged. For reads, ram_wdata is 0.
- R9: When a command and an access arrive in the same cycle, the access uses the page, column and mirror state from before the command. The command's value then becomes the new state, and a column load overrides the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 load page, 1 load column, 2 set mirror, 3 no operation |
| cmd_data | input | 8 | Command operand |
| acc_valid | input | 1 | Host data access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_wdata | input | 8 | Host write data |
| ram_req | output | 1 | Registered memory request |
| ram_we | output | 1 | Registered write enable |
| ram_page | output | 4 | Page of the request |
| ram_col | output | 8 | Physical column of the request |
| ram_wdata | output | 8 | Write data, masked on the icon page |
| cur_col | output | 8 | Logical column counter |
| cur_page | output | 4 | Page register |
| mirror_on | output | 1 | Column mirroring active |

## Verification
A command and a data access can fall in the same cycle, so a load or mirror change competes with the address and increment of the access. The bench drives each command kind on the same clock edge as an access. The scoreboard then requires that the request carries the page, column and mirror from before that edge. The following state check requires that the command's value, not the incremented count, is held afterwards.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
    typedef enum logic [1:0] {
        OP_PAGE   = 2'd0,
        OP_COL    = 2'd1,
        OP_MIRROR = 2'd2,
        OP_NOP    = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/dram_col_ctr.sv
module dram_col_ctr #(
    parameter int COL_W    = 8,
    parameter int NUM_COLS = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_val,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             locked
);
    localparam logic [COL_W-1:0] END_COL = COL_W'(NUM_COLS);

    typedef struct packed {
        logic [COL_W-1:0] col;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.col = load_val;
        end else if (step && (st_q.col < END_COL)) begin
            st_d.col = st_q.col + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col    = st_q.col;
    assign locked = (st_q.col >= END_COL);
endmodule

// File: rtl/dram_page_reg.sv
module dram_page_reg #(
    parameter int CMD_W     = 8,
    parameter int PAGE_W    = 4,
    parameter int NUM_PAGES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  load_val,
    output logic [PAGE_W-1:0] page
);
    localparam logic [CMD_W-1:0] LAST_PAGE = CMD_W'(NUM_PAGES - 1);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } pg_t;

    pg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && (load_val <= LAST_PAGE)) begin
            st_d.page = load_val[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page = st_q.page;
endmodule

// File: rtl/dram_col_map.sv
module dram_col_map #(
    parameter int COL_W    = 8,
    parameter int NUM_COLS = 132
) (
    input  logic             mirror,
    input  logic [COL_W-1:0] logical,
    output logic [COL_W-1:0] physical
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    always_comb begin
        if (mirror) physical = LAST_COL - logical;
        else        physical = logical;
    end
endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
    import dram_addr_pkg::*;
#(
    parameter int COL_W     = 8,
    parameter int NUM_COLS  = 132,
    parameter int PAGE_W    = 4,
    parameter int NUM_PAGES = 9,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [COL_W-1:0]  cmd_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [COL_W-1:0]  ram_col,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [COL_W-1:0]  cur_col,
    output logic [PAGE_W-1:0] cur_page,
    output logic              mirror_on
);
    localparam logic [PAGE_W-1:0] ICON_PAGE = PAGE_W'(NUM_PAGES - 1);
    localparam logic [DATA_W-1:0] ICON_MASK = DATA_W'(1);

    typedef struct packed {
        logic              mirror;
        logic              req;
        logic              we;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } top_t;

    top_t st_d, st_q;

    cmd_op_e          op;
    logic             col_load, page_load, mir_load;
    logic             locked, acc_ok;
    logic [COL_W-1:0] col_now, col_phys;
    logic [PAGE_W-1:0] page_now;

    assign op        = cmd_op_e'(cmd_op);
    assign col_load  = cmd_valid && (op == OP_COL);
    assign page_load = cmd_valid && (op == OP_PAGE);
    assign mir_load  = cmd_valid && (op == OP_MIRROR);
    assign acc_ok    = acc_valid && !locked;

    dram_col_ctr #(.COL_W(COL_W), .NUM_COLS(NUM_COLS)) i_col (
        .clk(clk), .rst_n(rst_n), .load(col_load), .load_val(cmd_data),
        .step(acc_ok), .col(col_now), .locked(locked)
    );

    dram_page_reg #(.CMD_W(COL_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) i_page (
        .clk(clk), .rst_n(rst_n), .load(page_load), .load_val(cmd_data),
        .page(page_now)
    );

    dram_col_map #(.COL_W(COL_W), .NUM_COLS(NUM_COLS)) i_map (
        .mirror(st_q.mirror), .logical(col_now), .physical(col_phys)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = acc_ok;
        st_d.we    = acc_ok && acc_write;
        st_d.page  = page_now;
        st_d.col   = col_phys;
        st_d.wdata = '0;
        if (acc_ok && acc_write) begin
            if (page_now == ICON_PAGE) st_d.wdata = acc_wdata & ICON_MASK;
            else                       st_d.wdata = acc_wdata;
        end
        if (mir_load) st_d.mirror = cmd_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_req   = st_q.req;
    assign ram_we    = st_q.we;
    assign ram_page  = st_q.page;
    assign ram_col   = st_q.col;
    assign ram_wdata = st_q.wdata;
    assign cur_col   = col_now;
    assign cur_page  = page_now;
    assign mirror_on = st_q.mirror;
endmodule

// File: rtl/dram_addr_chk.sv
module dram_addr_chk #(
    parameter int COL_W     = 8,
    parameter int NUM_COLS  = 132,
    parameter int PAGE_W    = 4,
    parameter int NUM_PAGES = 9,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [COL_W-1:0]  cmd_data,
    input logic              acc_valid,
    input logic              ram_req,
    input logic              ram_we,
    input logic [PAGE_W-1:0] ram_page,
    input logic [COL_W-1:0]  ram_col,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [COL_W-1:0]  cur_col,
    input logic [PAGE_W-1:0] cur_page
);
    localparam logic [COL_W-1:0]  END_COL   = COL_W'(NUM_COLS);
    localparam logic [COL_W-1:0]  LAST_PG   = COL_W'(NUM_PAGES - 1);
    localparam logic [PAGE_W-1:0] ICON_PAGE = PAGE_W'(NUM_PAGES - 1);

    // R5
    locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_col >= END_COL) |=> !ram_req);

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_col < END_COL && !(cmd_valid && cmd_op == 2'd1))
        |=> (cur_col == $past(cur_col) + COL_W'(1)));

    // R2
    page_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && cmd_data > LAST_PG) |=> $stable(cur_page));

    // R3
    col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=> (cur_col == $past(cmd_data)));

    // R7
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_req);

    // R6
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> (ram_col < END_COL));

    // R8
    icon_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_page == ICON_PAGE) |-> (ram_wdata[DATA_W-1:1] == '0));
endmodule

bind dram_addr_gen dram_addr_chk #(
    .COL_W(COL_W), .NUM_COLS(NUM_COLS), .PAGE_W(PAGE_W),
    .NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W)
) i_dram_addr_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .acc_valid(acc_valid), .ram_req(ram_req),
    .ram_we(ram_we), .ram_page(ram_page), .ram_col(ram_col),
    .ram_wdata(ram_wdata), .cur_col(cur_col), .cur_page(cur_page)
);

// File: tb/test_dram_addr_gen.sv
module test_dram_addr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd3;
    logic [7:0] cmd_data = '0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic       ram_req, ram_we, mirror_on;
    logic [3:0] ram_page, cur_page;
    logic [7:0] ram_col, ram_wdata, cur_col;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       we;
        logic [3:0] page;
        logic [7:0] col;
        logic [7:0] wdata;
    } item_t;

    item_t exp_q[$];

    logic [7:0] m_col;
    logic [3:0] m_page;
    logic       m_mir;

    always #10 clk = ~clk;

    dram_addr_gen i_dram_addr_gen (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .ram_req(ram_req), .ram_we(ram_we),
        .ram_page(ram_page), .ram_col(ram_col), .ram_wdata(ram_wdata),
        .cur_col(cur_col), .cur_page(cur_page), .mirror_on(mirror_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus; the model takes the state from before the edge
    task automatic step(input bit cv, input logic [1:0] op, input logic [7:0] cd,
                        input bit av, input bit wr, input logic [7:0] wd);
        item_t it;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_data = cd;
        acc_valid = av; acc_write = wr; acc_wdata = wd;
        if (av && m_col < 8'd132) begin
            it.we    = wr;
            it.page  = m_page;
            it.col   = m_mir ? (8'd131 - m_col) : m_col;
            it.wdata = !wr ? 8'h00 : (m_page == 4'd8 ? (wd & 8'h01) : wd);
            exp_q.push_back(it);
            m_col = m_col + 8'd1;
        end
        if (cv && op == 2'd0 && cd <= 8'd8) m_page = cd[3:0];
        if (cv && op == 2'd1) m_col = cd;
        if (cv && op == 2'd2) m_mir = cd[0];
        @(posedge clk);
        #2;
        cmd_valid = 1'b0; cmd_op = 2'd3; acc_valid = 1'b0;
    endtask

    task automatic state(input string req);
        @(negedge clk);
        chk({req, " cur_col"}, int'(cur_col), int'(m_col));
        chk({req, " cur_page"}, int'(cur_page), int'(m_page));
        chk({req, " mirror_on"}, int'(mirror_on), int'(m_mir));
    endtask

    // monitor: pop and compare each request the design produces
    always @(negedge clk) begin
        if (rst_n && ram_req) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected ram_req", 1, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk("R7 ram_we", int'(ram_we), int'(e.we));
                chk("R7 ram_page", int'(ram_page), int'(e.page));
                chk("R6 ram_col", int'(ram_col), int'(e.col));
                chk("R8 ram_wdata", int'(ram_wdata), int'(e.wdata));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_col = '0; m_page = '0; m_mir = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 ram_req", int'(ram_req), 0);
        state("R1");

        // R4 R6 R7 back-to-back writes on page 0
        for (int i = 0; i < 4; i++) step(0, 2'd3, 8'd0, 1, 1, 8'hA0 + 8'(i));
        state("R4");

        // R2 page load, R3 column load, reads
        step(1, 2'd0, 8'd3, 0, 0, 8'd0);
        step(1, 2'd1, 8'd10, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 0, 8'h55);
        step(0, 2'd3, 8'd0, 1, 0, 8'h55);
        state("R3");
        step(1, 2'd0, 8'd9, 0, 0, 8'd0);
        state("R2 page 9 ignored");
        step(1, 2'd0, 8'hF3, 0, 0, 8'd0);
        state("R2 page 0xF3 ignored");

        // R8 icon page
        step(1, 2'd0, 8'd8, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'hFF);
        step(0, 2'd3, 8'd0, 1, 1, 8'hFE);
        state("R8");

        // R5 lock at the end of the row
        step(1, 2'd0, 8'd2, 0, 0, 8'd0);
        step(1, 2'd1, 8'd130, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'h11);
        step(0, 2'd3, 8'd0, 1, 1, 8'h22);
        step(0, 2'd3, 8'd0, 1, 1, 8'h33);
        step(0, 2'd3, 8'd0, 1, 0, 8'h00);
        state("R5 locked at 132");
        chk("R5 cur_col", int'(cur_col), 132);
        // R3 release
        step(1, 2'd1, 8'd0, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'h44);
        state("R3 released");

        // R6 mirror
        step(1, 2'd2, 8'd1, 0, 0, 8'd0);
        step(1, 2'd1, 8'd0, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'h66);
        step(1, 2'd1, 8'd131, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'h77);
        state("R6 mirror");

        // R9 same-cycle command and access
        step(1, 2'd1, 8'd40, 0, 0, 8'd0);
        step(1, 2'd1, 8'd7, 1, 1, 8'h88);
        state("R9 col load wins");
        step(1, 2'd0, 8'd5, 1, 1, 8'h99);
        state("R9 page load");
        step(1, 2'd2, 8'd0, 1, 0, 8'h00);
        state("R9 mirror set");
        step(0, 2'd3, 8'd0, 1, 1, 8'hBB);

        // R5 R3 load of a locked value
        step(1, 2'd1, 8'hFF, 0, 0, 8'd0);
        step(0, 2'd3, 8'd0, 1, 1, 8'hCC);
        state("R5 load 0xFF");

        repeat (3) @(negedge clk);
        chk("R7 all requests seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule